// File: doc/BRIEF.md
# B8ZS AMI Transmit Encoder

This block turns a transmit bit stream, one bit per clock, into positive and negative rail pulse requests for a bipolar line driver. In single-rail mode every mark becomes a pulse whose polarity is the opposite of the pulse before it. Spaces produce no pulse. When zero substitution is enabled, any run of eight spaces is replaced by a code made of three nulls, a violation, a correct pulse, a null, a violation and a correct pulse. The substitution keeps pulse density on the line without disturbing alternation after the code. To allow this, bits pass through an eight-slot window before they reach the rails.

In dual-rail mode the caller supplies both rails directly, and the shared negative-data pin then carries the negative rail instead of the substitution enable. Two overrides act at the output register:
- an all-ones alarm stream (AIS), which alternates polarity;
- a remote-loopback path that forwards externally supplied rails.

The alarm stream has priority over the loopback. The block works in a single clock domain: the alarm stream advances on the same clock as the data.

Top module: `b8zs_tx_encoder`

## Requirements
- R1: A bit sampled at clock edge k reaches the rails at edge k+8 (visible after that edge), in both single-rail and dual-rail mode, when neither override is active at edge k+8.
- R2: In single-rail mode (`dual_sel`=0) with substitution off (`tx_neg_zsub`=0), a 1 produces one pulse with the opposite polarity to the previous line pulse, and a 0 produces neither rail.
- R3: While `rst` is high the rails are low and the polarity state is cleared, so the first alternating pulse after reset is positive (`rail_p`).
- R4: In single-rail mode with `tx_neg_zsub`=1, eight consecutive zeros that belong to no earlier code are sent as null,null,null,V,B,null,V,B in time order. V has the same polarity as the previous pulse and B the opposite. A run of 16 zeros gives two codes, and a run of 7 gives none.
- R5: After a substitution code the polarity state equals that of the last B, so the next mark has the opposite polarity to that B.
- R6: In dual-rail mode, `tx_data`=1 drives `rail_p` and `tx_neg_zsub`=1 drives `rail_n`. Both high yields no pulse. Dual-rail bits leave the polarity state unchanged.
- R7: While `blue_tx` is high at an edge, the rails after that edge carry exactly one pulse, alternating with the previous pulse. The data still advances through the window.
- R8: While `rloop_req` is high and `blue_tx` low at an edge, the rails after that edge equal `rloop_p`/`rloop_n` from that edge, with both high giving no pulse. The polarity state is unchanged.
- R9: With `blue_tx` and `rloop_req` both high, the alarm stream of R7 is sent and the looped rails are ignored.
- R10: `rail_p` and `rail_n` are never high after the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one bit per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| tx_data | input | 1 | Unipolar data (single-rail) or positive rail (dual-rail) |
| tx_neg_zsub | input | 1 | Substitution enable (single-rail) or negative rail (dual-rail) |
| dual_sel | input | 1 | 1 selects dual-rail mode |
| blue_tx | input | 1 | Sends the all-ones alarm stream |
| rloop_req | input | 1 | Selects the remote-loopback rails |
| rloop_p | input | 1 | Looped positive rail |
| rloop_n | input | 1 | Looped negative rail |
| rail_p | output | 1 | Registered positive pulse request |
| rail_n | output | 1 | Registered negative pulse request |

## Verification
The bench uses the default window depth of eight. This is the depth that the eight-position substitution code occupies, so R1 latency, code placement and the run-boundary cases (7, 8 and 16 zeros) are all reachable. The bench switches modes and overrides while data is still inside the window. This shows that polarity continues correctly across dual-rail bits, alarm pulses and loopback cycles.

// File: rtl/b8zs_tx_pkg.sv
`timescale 1ns/1ps
package b8zs_tx_pkg;

  localparam int ZRUN = 8;

  typedef enum logic [1:0] {
    SUB_NONE = 2'd0,
    SUB_V    = 2'd1,
    SUB_B    = 2'd2
  } sub_e;

  typedef struct packed {
    logic dual;
    logic mark;
    logic neg;
    sub_e sub;
  } slot_t;

  // Slot 0 is the newest bit; slot ZRUN-1 leaves first.
  function automatic sub_e sub_code(input int unsigned idx);
    case (idx)
      0, 3:    sub_code = SUB_B;
      1, 4:    sub_code = SUB_V;
      default: sub_code = SUB_NONE;
    endcase
  endfunction

endpackage

// File: rtl/b8zs_zero_window.sv
`timescale 1ns/1ps
module b8zs_zero_window
  import b8zs_tx_pkg::*;
#(
  parameter int DEPTH = ZRUN
) (
  input  logic  clk,
  input  logic  rst,
  input  slot_t slot_in,
  input  logic  sub_en,
  output slot_t slot_out
);

  slot_t line_q [DEPTH];
  slot_t cand   [DEPTH];
  logic  run_hit;

  always_comb begin
    cand[0] = slot_in;
    for (int i = 1; i < DEPTH; i++) begin
      cand[i] = line_q[i-1];
    end
    run_hit = sub_en;
    for (int i = 0; i < DEPTH; i++) begin
      if (cand[i].dual || cand[i].mark || (cand[i].sub != SUB_NONE)) begin
        run_hit = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) begin
        line_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        line_q[i] <= cand[i];
        if (run_hit) begin
          line_q[i].sub <= sub_code(i);
        end
      end
    end
  end

  assign slot_out = line_q[DEPTH-1];

endmodule

// File: rtl/b8zs_rail_former.sv
`timescale 1ns/1ps
module b8zs_rail_former
  import b8zs_tx_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  slot_t slot,
  input  logic  blue_tx,
  input  logic  rloop_req,
  input  logic  rloop_p,
  input  logic  rloop_n,
  output logic  rail_p,
  output logic  rail_n
);

  logic last_pos_q;
  logic nxt_p, nxt_n, flip;

  always_comb begin
    nxt_p = 1'b0;
    nxt_n = 1'b0;
    flip  = 1'b0;
    if (blue_tx) begin
      nxt_p = ~last_pos_q;
      nxt_n = last_pos_q;
      flip  = 1'b1;
    end else if (rloop_req) begin
      nxt_p = rloop_p & ~rloop_n;
      nxt_n = rloop_n & ~rloop_p;
    end else if (slot.dual) begin
      nxt_p = slot.mark & ~slot.neg;
      nxt_n = slot.neg & ~slot.mark;
    end else begin
      case (slot.sub)
        SUB_V: begin
          nxt_p = last_pos_q;
          nxt_n = ~last_pos_q;
        end
        SUB_B: begin
          nxt_p = ~last_pos_q;
          nxt_n = last_pos_q;
          flip  = 1'b1;
        end
        default: begin
          if (slot.mark) begin
            nxt_p = ~last_pos_q;
            nxt_n = last_pos_q;
            flip  = 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      last_pos_q <= 1'b0;
      rail_p     <= 1'b0;
      rail_n     <= 1'b0;
    end else begin
      if (flip) begin
        last_pos_q <= ~last_pos_q;
      end
      rail_p <= nxt_p;
      rail_n <= nxt_n;
    end
  end

endmodule

// File: rtl/b8zs_tx_encoder.sv
`timescale 1ns/1ps
module b8zs_tx_encoder
  import b8zs_tx_pkg::*;
#(
  parameter int DEPTH = ZRUN
) (
  input  logic clk,
  input  logic rst,
  input  logic tx_data,
  input  logic tx_neg_zsub,
  input  logic dual_sel,
  input  logic blue_tx,
  input  logic rloop_req,
  input  logic rloop_p,
  input  logic rloop_n,
  output logic rail_p,
  output logic rail_n
);

  slot_t in_slot;
  slot_t out_slot;
  logic  sub_en;

  always_comb begin
    in_slot.dual = dual_sel;
    in_slot.mark = tx_data;
    in_slot.neg  = dual_sel & tx_neg_zsub;
    in_slot.sub  = SUB_NONE;
  end

  assign sub_en = ~dual_sel & tx_neg_zsub;

  b8zs_zero_window #(.DEPTH(DEPTH)) u_window (
    .clk      (clk),
    .rst      (rst),
    .slot_in  (in_slot),
    .sub_en   (sub_en),
    .slot_out (out_slot)
  );

  b8zs_rail_former u_former (
    .clk       (clk),
    .rst       (rst),
    .slot      (out_slot),
    .blue_tx   (blue_tx),
    .rloop_req (rloop_req),
    .rloop_p   (rloop_p),
    .rloop_n   (rloop_n),
    .rail_p    (rail_p),
    .rail_n    (rail_n)
  );

endmodule

// File: rtl/b8zs_tx_encoder_sva.sv
`timescale 1ns/1ps
module b8zs_tx_encoder_sva (
  input logic clk,
  input logic rst,
  input logic tx_data,
  input logic tx_neg_zsub,
  input logic dual_sel,
  input logic blue_tx,
  input logic rloop_req,
  input logic rloop_p,
  input logic rloop_n,
  input logic rail_p,
  input logic rail_n
);

  logic [3:0] live_q;

  always_ff @(posedge clk) begin
    if (rst) live_q <= 4'd0;
    else if (live_q != 4'd15) live_q <= live_q + 4'd1;
  end

  assert_reset_quiet_R3: assert property (@(posedge clk)
    rst |=> (!rail_p && !rail_n));

  assert_rails_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
    (live_q >= 4'd1) |-> !(rail_p && rail_n));

  assert_ais_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    (live_q >= 4'd1 && $past(blue_tx)) |-> (rail_p ^ rail_n));

  assert_ais_alternate_R7: assert property (@(posedge clk) disable iff (rst)
    (live_q >= 4'd2 && $past(blue_tx) && $past(blue_tx, 2) && rail_p) |-> $past(rail_n));

  assert_loop_pass_R8: assert property (@(posedge clk) disable iff (rst)
    (live_q >= 4'd1 && $past(rloop_req && !blue_tx)) |->
      (rail_p == $past(rloop_p && !rloop_n) && rail_n == $past(rloop_n && !rloop_p)));

  assert_dual_pass_R6: assert property (@(posedge clk) disable iff (rst)
    (live_q >= 4'd9 && $past(dual_sel, 9) && !$past(blue_tx) && !$past(rloop_req)) |->
      (rail_p == $past(tx_data && !tx_neg_zsub, 9) && rail_n == $past(tx_neg_zsub && !tx_data, 9)));

endmodule

bind b8zs_tx_encoder b8zs_tx_encoder_sva u_sva (
  .clk         (clk),
  .rst         (rst),
  .tx_data     (tx_data),
  .tx_neg_zsub (tx_neg_zsub),
  .dual_sel    (dual_sel),
  .blue_tx     (blue_tx),
  .rloop_req   (rloop_req),
  .rloop_p     (rloop_p),
  .rloop_n     (rloop_n),
  .rail_p      (rail_p),
  .rail_n      (rail_n)
);

// File: tb/b8zs_tx_encoder_test.sv
`timescale 1ns/1ps
module b8zs_tx_encoder_test;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tx_data = 1'b0, tx_neg_zsub = 1'b0, dual_sel = 1'b0;
  logic blue_tx = 1'b0, rloop_req = 1'b0, rloop_p = 1'b0, rloop_n = 1'b0;
  logic rail_p, rail_n;

  always #2.5 clk = ~clk;

  b8zs_tx_encoder uut (
    .clk(clk), .rst(rst), .tx_data(tx_data), .tx_neg_zsub(tx_neg_zsub),
    .dual_sel(dual_sel), .blue_tx(blue_tx), .rloop_req(rloop_req),
    .rloop_p(rloop_p), .rloop_n(rloop_n), .rail_p(rail_p), .rail_n(rail_n)
  );

  localparam int OFF = 16;
  localparam int NB  = 4096;

  typedef struct {
    int    cyc;
    bit    p;
    bit    n;
    string tag;
  } exp_t;

  exp_t q[$];
  bit   m_mark [NB];
  bit   m_neg  [NB];
  bit   m_dual [NB];
  int   m_sub  [NB];   // 0 none, 1 V, 2 B
  bit   mpol = 1'b0;   // 1: last pulse was positive
  int   edge_n = 0;
  int   total = 0;
  int   bad = 0;

  // Monitor: compare queued expectations against the rails after each edge.
  initial begin
    forever begin
      @(posedge clk);
      edge_n++;
      #1;
      while (q.size() > 0 && q[0].cyc <= edge_n) begin
        exp_t it;
        it = q.pop_front();
        if (it.cyc == edge_n) begin
          total++;
          if (rail_p !== it.p || rail_n !== it.n) begin
            bad++;
            $display("FAIL %s edge %0d: rails p=%b n=%b expected p=%b n=%b",
                     it.tag, edge_n, rail_p, rail_n, it.p, it.n);
          end
        end
      end
      if (edge_n > 1) begin
        total++;
        if (rail_p === 1'b1 && rail_n === 1'b1) begin
          bad++;
          $display("FAIL R10 edge %0d: rails p=%b n=%b expected not both high",
                   edge_n, rail_p, rail_n);
        end
      end
    end
  end

  task automatic rst_step();
    exp_t it;
    @(negedge clk);
    rst = 1'b1;
    it.cyc = edge_n + 1; it.p = 1'b0; it.n = 1'b0; it.tag = "R3";
    q.push_back(it);
  endtask

  task automatic step(input bit d, input bit ng, input bit du, input bit bl,
                      input bit lr, input bit lp, input bit ln, input string tag);
    int   c;
    int   b;
    bit   clean;
    exp_t it;
    @(negedge clk);
    rst = 1'b0;
    tx_data = d; tx_neg_zsub = ng; dual_sel = du;
    blue_tx = bl; rloop_req = lr; rloop_p = lp; rloop_n = ln;
    c = edge_n + 1 + OFF;
    m_mark[c] = d; m_dual[c] = du; m_neg[c] = du & ng; m_sub[c] = 0;
    if (!du && ng) begin
      clean = 1'b1;
      for (int j = 0; j < 8; j++) begin
        if (m_mark[c-j] || m_dual[c-j] || m_sub[c-j] != 0) clean = 1'b0;
      end
      if (clean) begin
        m_sub[c]   = 2; m_sub[c-1] = 1;
        m_sub[c-3] = 2; m_sub[c-4] = 1;
      end
    end
    it.cyc = c - OFF; it.tag = tag; it.p = 1'b0; it.n = 1'b0;
    b = c - 8;
    if (bl) begin
      it.p = !mpol; it.n = mpol; mpol = !mpol;
    end else if (lr) begin
      it.p = lp & !ln; it.n = ln & !lp;
    end else if (m_dual[b]) begin
      it.p = m_mark[b] & !m_neg[b]; it.n = m_neg[b] & !m_mark[b];
    end else if (m_sub[b] == 1) begin
      it.p = mpol; it.n = !mpol;
    end else if (m_sub[b] == 2 || m_mark[b]) begin
      it.p = !mpol; it.n = mpol; mpol = !mpol;
    end
    q.push_back(it);
  endtask

  task automatic sbit(input bit d, input bit zs, input string tag);
    step(d, zs, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) sbit(1'b0, 1'b0, tag);
  endtask

  task automatic zeros(input int n, input string tag);
    for (int i = 0; i < n; i++) sbit(1'b0, 1'b1, tag);
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    finish_run();
  end

  initial begin
    // R3: reset state, then the first mark must go out positive.
    rst_step(); rst_step(); rst_step();
    sbit(1'b1, 1'b0, "R3");
    idle(9, "R3");

    // R2: plain alternate mark inversion, R1 latency implied by alignment.
    sbit(1'b1, 1'b0, "R2"); sbit(1'b1, 1'b0, "R2"); sbit(1'b0, 1'b0, "R2");
    sbit(1'b1, 1'b0, "R2"); sbit(1'b0, 1'b0, "R2"); sbit(1'b0, 1'b0, "R2");
    sbit(1'b1, 1'b1, "R2"); sbit(1'b1, 1'b0, "R2"); sbit(1'b1, 1'b0, "R2");
    idle(8, "R1");

    // R6 and R1 in dual-rail mode, then single-rail continuity.
    step(1, 0, 1, 0, 0, 0, 0, "R6"); step(0, 1, 1, 0, 0, 0, 0, "R6");
    step(1, 1, 1, 0, 0, 0, 0, "R6"); step(0, 0, 1, 0, 0, 0, 0, "R6");
    step(0, 1, 1, 0, 0, 0, 0, "R1");
    sbit(1'b1, 1'b0, "R6"); sbit(1'b1, 1'b0, "R6");
    idle(8, "R6");

    // R4: single run of eight, then sixteen, then seven zeros.
    sbit(1'b1, 1'b1, "R4");
    zeros(8, "R4");
    sbit(1'b1, 1'b1, "R5"); sbit(1'b1, 1'b1, "R5");
    zeros(16, "R4");
    sbit(1'b1, 1'b1, "R5");
    zeros(7, "R4");
    sbit(1'b1, 1'b1, "R4");
    sbit(1'b0, 1'b1, "R4");
    sbit(1'b1, 1'b1, "R4");
    idle(9, "R5");

    // R7: alarm stream while data keeps moving through the window.
    sbit(1'b1, 1'b0, "R7");
    step(1, 0, 0, 1, 0, 0, 0, "R7"); step(0, 0, 0, 1, 0, 0, 0, "R7");
    step(1, 0, 0, 1, 0, 0, 0, "R7"); step(1, 0, 0, 1, 0, 0, 0, "R7");
    step(0, 0, 0, 1, 0, 0, 0, "R7"); step(0, 0, 0, 1, 0, 0, 0, "R7");
    idle(9, "R7");

    // R8: loopback rails, including both high.
    step(1, 0, 0, 0, 1, 1, 0, "R8"); step(0, 0, 0, 0, 1, 0, 1, "R8");
    step(1, 0, 0, 0, 1, 1, 1, "R8"); step(0, 0, 0, 0, 1, 0, 0, "R8");
    step(0, 0, 0, 0, 1, 1, 0, "R8");
    idle(8, "R8");

    // R9: alarm wins over loopback.
    step(0, 0, 0, 1, 1, 1, 0, "R9"); step(0, 0, 0, 1, 1, 0, 1, "R9");
    step(0, 0, 0, 1, 1, 1, 1, "R9"); step(0, 0, 0, 1, 1, 0, 0, "R9");
    sbit(1'b1, 1'b0, "R9");
    idle(10, "R9");

    repeat (4) @(posedge clk);
    #2;
    finish_run();
  end

endmodule